// File: doc/BRIEF.md
# Sub-pixel refocusing boxcar filter

This block refocuses one row of a light-field image on the fly. The input is a raster stream of sensor pixels that are grouped into micro images, each `m` pixels wide. Every accepted input pixel is expanded by nearest-neighbour repetition into `m` output slots, so the output stream is `m` times as long as the input stream. Each output slot is the average of `m` consecutive input pixels taken from a short history.

A phase counter steps through the `m` slots of the current pixel. Together with the programmed sub-pixel shift `a'` (the shift is a'/m of a micro image pixel), the phase picks where the averaging window starts in the history. This lets larger shifts combine pixels that lie further back. The divide by `m` is never computed at run time. Each pixel is scaled on entry by reading a table of precomputed products that keeps `FRAC_W` fraction bits. A register stage fans the history out to the switched adder tree, and the sum is registered at the output.

Both stream edges use valid/ready handshakes. A word moves on an edge where valid and ready are both high. `in_ready` may depend combinationally on `out_ready`. While `out_valid` is high and `out_ready` is low, the whole pipeline holds: `out_pixel` stays unchanged and `in_ready` is low. Width and shift are sampled only with the pixel that carries `in_sol`.

Top module: `refocus_boxcar`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted pixel q enters the history as floor(q·2^FRAC_W / m), with FRAC_W = 4 by default. Each output is the sum of the `m` selected history entries shifted right by FRAC_W. A constant 100 with m = 3 therefore settles at 99, and a constant 255 settles at 255.
- R3: Each accepted pixel yields exactly `m` output words. When the output is never stalled, successive input pixels are accepted exactly `m` cycles apart.
- R4: For output slot `ph` (0 to m-1) of input pixel n, the window starts at s = ph·(a'-1), with a' = 0 treated as 1. The output averages pixels n-s down to n-s-m+1. For m = 3 this gives {n, n-1, n-2} in every slot when a' = 1, and it gives {n-ph, ..., n-ph-2} when a' = 2.
- R5: A pixel accepted with `in_sol` = 1 starts a new line. Every earlier pixel counts as 0 in the history, and the phase restarts at 0.
- R6: With `out_ready` held at 1, the first output of a pixel is presented three clock edges after the edge that accepted the pixel: one edge for the table read, one for the fan-out register and one for the sum register.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_pixel` and `out_valid` hold and `in_ready` is 0. A stalled run produces the same output sequence as an unstalled one.
- R8: `in_width` and `in_shift` are latched only on a pixel accepted with `in_sol` = 1. Their values on the other pixels of the line have no effect.
- R9: A width of 0 is used as 1 and a width above M_MAX is used as M_MAX. A shift above M_MAX-1 is used as M_MAX-1. With M_MAX = 6, a width of 7 and a shift of 7 behave as width 6 and shift 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_data | input | PIX_W | Input pixel value |
| in_sol | input | 1 | Marks the first pixel of a line |
| in_width | input | $clog2(M_MAX+1) | Micro image width m, sampled with `in_sol` |
| in_shift | input | $clog2(M_MAX+1) | Sub-pixel shift a', sampled with `in_sol` |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pixel | output | PIX_W | Refocused output pixel |

## Verification
The assertions cover the handshake on every cycle. They check that output data holds during a stall and that input is refused while stalled. They also check that the phase counter stays below the latched width and that a line start clears the history. Further cycle checks cover tap selection, which must always enable exactly `m` taps, the bound on the scaled product, and the advance from the fan-out stage to the output register. Only the bench scenarios can show that the window position for each phase and shift is correct, that the arithmetic matches the rounding rule, that the latency and input spacing are exact, and that width and shift values sent mid-line are ignored. The bench checks these by comparing whole output sequences against a model for several widths, shifts and stall patterns.

// File: rtl/refocus_pkg.sv
package refocus_pkg;

  // Coerce a requested micro image width into 1..mmax
  function automatic int unsigned fit_width(int unsigned w, int unsigned mmax);
    if (w == 0) return 1;
    if (w > mmax) return mmax;
    return w;
  endfunction

  // Coerce a requested sub-pixel shift into 0..amax
  function automatic int unsigned fit_shift(int unsigned a, int unsigned amax);
    return (a > amax) ? amax : a;
  endfunction

  // Window start for a phase at a given shift
  function automatic int unsigned window_start(int unsigned a, int unsigned ph);
    return (a <= 1) ? 0 : ph * (a - 1);
  endfunction

endpackage

// File: rtl/refocus_scale_rom.sv
module refocus_scale_rom #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 4,
  parameter int M_MAX  = 6,
  localparam int MW     = $clog2(M_MAX + 1),
  localparam int PROD_W = PIX_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MW-1:0]     width,
  input  logic [PIX_W-1:0]  pix,
  output logic [PROD_W-1:0] prod
);

  localparam int NVAL = 2 ** PIX_W;

  logic [PROD_W-1:0] tbl [M_MAX][NVAL];

  for (genvar w = 0; w < M_MAX; w++) begin : g_w
    for (genvar v = 0; v < NVAL; v++) begin : g_v
      assign tbl[w][v] = PROD_W'((v * (2 ** FRAC_W)) / (w + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      prod <= '0;
    else if (en)
      prod <= tbl[width - MW'(1)][pix];
  end

  // R2
  prod_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (int'(prod) * int'($past(width))) <= (int'($past(pix)) * (2 ** FRAC_W)));

endmodule

// File: rtl/refocus_fanout.sv
module refocus_fanout #(
  parameter int W = 12,
  parameter int N = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d [N],
  output logic [W-1:0] q [N]
);

  for (genvar i = 0; i < N; i++) begin : g_leaf
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[i] <= '0;
      else if (en)
        q[i] <= d[i];
    end
  end

endmodule

// File: rtl/refocus_tap_sel.sv
module refocus_tap_sel #(
  parameter int M_MAX = 6,
  parameter int DEPTH = 26,
  localparam int MW = $clog2(M_MAX + 1),
  localparam int SW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MW-1:0]    width,
  input  logic [MW-1:0]    shift,
  input  logic [MW-1:0]    phase,
  output logic [DEPTH-1:0] mask
);
  import refocus_pkg::*;

  logic [SW-1:0] start_tbl [M_MAX][M_MAX];

  for (genvar a = 0; a < M_MAX; a++) begin : g_a
    for (genvar p = 0; p < M_MAX; p++) begin : g_p
      assign start_tbl[a][p] = SW'(window_start(a, p));
    end
  end

  logic [SW-1:0] start;
  logic [SW:0]   stop;

  always_comb begin
    start = start_tbl[shift][phase];
    stop  = {1'b0, start} + (SW+1)'(width);
    for (int j = 0; j < DEPTH; j++)
      mask[j] = ((SW+1)'(j) >= {1'b0, start}) && ((SW+1)'(j) < stop);
  end

  // R4
  tap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask) == int'(width));

endmodule

// File: rtl/refocus_boxcar.sv
module refocus_boxcar #(
  parameter int PIX_W  = 8,
  parameter int M_MAX  = 6,
  parameter int FRAC_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [PIX_W-1:0]             in_data,
  input  logic                         in_sol,
  input  logic [$clog2(M_MAX+1)-1:0]   in_width,
  input  logic [$clog2(M_MAX+1)-1:0]   in_shift,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [PIX_W-1:0]             out_pixel
);
  import refocus_pkg::*;

  localparam int MW     = $clog2(M_MAX + 1);
  localparam int DEPTH  = (M_MAX - 1) * (M_MAX - 2) + M_MAX;
  localparam int PROD_W = PIX_W + FRAC_W;
  localparam int SUM_W  = PROD_W + MW;

  // handshake and stage control
  logic          adv, acc;
  logic          s1_valid;
  logic [MW-1:0] ph, m_cur, a_cur;
  logic [MW-1:0] m_in_fit, a_in_fit, m_use;
  logic          last_ph;

  assign adv      = !out_valid || out_ready;
  assign last_ph  = (ph == m_cur - MW'(1));
  assign in_ready = adv && (!s1_valid || last_ph);
  assign acc      = in_valid && in_ready;

  assign m_in_fit = MW'(fit_width(int'(in_width), M_MAX));
  assign a_in_fit = MW'(fit_shift(int'(in_shift), M_MAX - 1));
  assign m_use    = in_sol ? m_in_fit : m_cur;

  // scaled product of the newest pixel is tap 0
  logic [PROD_W-1:0] newest;

  refocus_scale_rom #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .M_MAX(M_MAX)) u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (acc),
    .width (m_use),
    .pix   (in_data),
    .prod  (newest)
  );

  // older history
  logic [PROD_W-1:0] hist [1:DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 1; j < DEPTH; j++) hist[j] <= '0;
    end else if (acc) begin
      if (in_sol) begin
        for (int j = 1; j < DEPTH; j++) hist[j] <= '0;
      end else begin
        hist[1] <= newest;
        for (int j = 2; j < DEPTH; j++) hist[j] <= hist[j-1];
      end
    end
  end

  // phase counter and line parameters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      ph       <= '0;
      m_cur    <= MW'(1);
      a_cur    <= MW'(1);
    end else if (adv) begin
      if (acc) begin
        s1_valid <= 1'b1;
        ph       <= '0;
        if (in_sol) begin
          m_cur <= m_in_fit;
          a_cur <= a_in_fit;
        end
      end else if (s1_valid && !last_ph) begin
        ph <= ph + MW'(1);
      end else begin
        s1_valid <= 1'b0;
      end
    end
  end

  // fan-out register stage
  logic [PROD_W-1:0] taps   [DEPTH];
  logic [PROD_W-1:0] t2_taps[DEPTH];
  logic              t2_valid;
  logic [MW-1:0]     t2_ph, t2_m, t2_a;

  always_comb begin
    taps[0] = newest;
    for (int j = 1; j < DEPTH; j++) taps[j] = hist[j];
  end

  refocus_fanout #(.W(PROD_W), .N(DEPTH)) u_fan (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .d     (taps),
    .q     (t2_taps)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t2_valid <= 1'b0;
      t2_ph    <= '0;
      t2_m     <= MW'(1);
      t2_a     <= MW'(1);
    end else if (adv) begin
      t2_valid <= s1_valid;
      t2_ph    <= ph;
      t2_m     <= m_cur;
      t2_a     <= a_cur;
    end
  end

  // switched adder tree
  logic [DEPTH-1:0] sel;
  logic [SUM_W-1:0] sum;

  refocus_tap_sel #(.M_MAX(M_MAX), .DEPTH(DEPTH)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .width (t2_m),
    .shift (t2_a),
    .phase (t2_ph),
    .mask  (sel)
  );

  always_comb begin
    sum = '0;
    for (int j = 0; j < DEPTH; j++)
      if (sel[j]) sum = sum + SUM_W'(t2_taps[j]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else if (adv) begin
      out_valid <= t2_valid;
      if (t2_valid) out_pixel <= PIX_W'(sum >> FRAC_W);
    end
  end

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

  // R7
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (ph < m_cur));

  // R5
  sol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sol) |=> (hist[1] == '0));

  // R6
  pipe_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_valid && adv) |=> out_valid);

endmodule

// File: tb/test_refocus_boxcar.sv
module test_refocus_boxcar;

  localparam int PW = 8;
  localparam int MM = 6;
  localparam int FW = 4;
  localparam int MW = $clog2(MM + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_data = '0;
  logic          in_sol = 1'b0;
  logic [MW-1:0] in_width = '0;
  logic [MW-1:0] in_shift = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_pixel;

  refocus_boxcar #(.PIX_W(PW), .M_MAX(MM), .FRAC_W(FW)) i_refocus_boxcar (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .in_width(in_width), .in_shift(in_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_mode = 0;
  int got [0:511];
  int got_cyc [0:511];
  int got_n = 0;
  int acc_cyc [0:63];
  int pix [0:63];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // output monitor: decides out_ready, then records words that will transfer
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        got[got_n] = int'(out_pixel);
        got_cyc[got_n] = cyc;
        got_n++;
      end
    end
  end

  task automatic send_pix(input int q, input bit sol, input int w, input int a, output int at);
    @(negedge clk);
    #2;
    in_valid = 1'b1; in_data = PW'(q); in_sol = sol;
    in_width = MW'(w); in_shift = MW'(a);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
    at = cyc;
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_sol = 1'b0;
  endtask

  // send a line (pixel values in pix[]), drain, compare against the model
  task automatic run_line(input int len, input int w_sol, input int a_sol,
                          input int w_mid, input int a_mid, input string req);
    int w, a, exp_n;
    got_n = 0;
    for (int n = 0; n < len; n++)
      send_pix(pix[n], n == 0, (n == 0) ? w_sol : w_mid, (n == 0) ? a_sol : a_mid, acc_cyc[n]);
    repeat (60) @(negedge clk);
    w = (w_sol == 0) ? 1 : ((w_sol > MM) ? MM : w_sol);
    a = (a_sol > MM - 1) ? MM - 1 : a_sol;
    exp_n = len * w;
    check(got_n == exp_n, {req, " count"}, got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      int n, ph, s, sum, e;
      n = k / w; ph = k % w;
      s = (a <= 1) ? 0 : ph * (a - 1);
      sum = 0;
      for (int i = 0; i < w; i++) begin
        int idx;
        idx = n - s - i;
        if (idx >= 0) sum += (pix[idx] * (2 ** FW)) / w;
      end
      e = sum >> FW;
      check(got[k] == e, req, got[k], e);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic test_shift_one();
    for (int n = 0; n < 10; n++) pix[n] = (n * 23 + 5) % 256;
    run_line(10, 3, 1, 3, 1, "R4 m3 shift1");
    // R6: first output three edges after acceptance
    check(got_cyc[0] - acc_cyc[0] == 3, "R6 latency", got_cyc[0] - acc_cyc[0], 3);
    // R3: input spacing equals width
    check(acc_cyc[1] - acc_cyc[0] == 3, "R3 input spacing", acc_cyc[1] - acc_cyc[0], 3);
  endtask

  task automatic test_shift_two();
    for (int n = 0; n < 10; n++) pix[n] = (n * 37 + 11) % 256;
    run_line(10, 3, 2, 3, 2, "R4 m3 shift2");
  endtask

  task automatic test_scale();
    for (int n = 0; n < 6; n++) pix[n] = 100;
    run_line(6, 3, 1, 3, 1, "R2 const100");
    check(got[17] == 99, "R2 settled 100", got[17], 99);
    for (int n = 0; n < 6; n++) pix[n] = 255;
    run_line(6, 3, 1, 3, 1, "R2 const255");
    check(got[17] == 255, "R2 settled 255", got[17], 255);
  endtask

  task automatic test_backpressure();
    for (int n = 0; n < 9; n++) pix[n] = (n * 11 + 200) % 256;
    stall_mode = 1;
    run_line(9, 3, 2, 3, 2, "R7 stalled");
    stall_mode = 0;
  endtask

  task automatic test_latch_and_line();
    // R8: mid-line width/shift values differ and must be ignored; R5: fresh line
    for (int n = 0; n < 8; n++) pix[n] = (n * 29 + 90) % 256;
    run_line(8, 4, 3, 2, 1, "R8 R5 m4 shift3");
  endtask

  task automatic test_clamp();
    for (int n = 0; n < 5; n++) pix[n] = (n * 41 + 17) % 256;
    run_line(5, 7, 7, 7, 7, "R9 clamp");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_shift_one();
    test_shift_two();
    test_scale();
    test_backpressure();
    test_latch_and_line();
    test_clamp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule